// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Neuron

This block models one spiking neuron for an event-driven network. Every input event carries a signed synaptic weight in fixed point: integer bits with the sign included, followed by fractional bits. The block adds that weight straight into a membrane potential. A separate time-step tick makes the potential decay toward zero by subtracting a right-shifted copy of itself. When the potential reaches the threshold of 1.0, the block emits a single-cycle spike and clears the potential. The neuron then stays refractory for a configurable number of ticks. During that time it neither integrates nor fires.

The potential register is wider than a weight by a few guard bits. It saturates at both ends of its range instead of wrapping. A weight that quantized to zero leaves the potential untouched, so callers may drop such synapses without any change in behaviour. The potential is brought out so a neighbouring block can observe it.

Top module: `lif_neuron`

## Requirements
- R1: Synchronous active-high reset clears the potential to 0, holds `spike_o` low and leaves the neuron non-refractory.
- R2: An accepted event adds its weight (two's complement, `W_INT+W_FRAC` bits, value = raw / 2^W_FRAC; default 7 bits, raw/16) to the potential, visible on `v_mem_o` (same fixed point, `GUARD` extra integer bits) one cycle later.
- R3: An event whose weight is zero leaves the potential unchanged.
- R4: A tick replaces the potential v by v - (v >>> k), an arithmetic shift with k = `cfg_leak_shift_i`, so both positive and negative values move toward zero.
- R5: When a tick and an event fall in the same cycle, the leak is applied first, then the weight is added, then the threshold is compared.
- R6: A potential that reaches or exceeds 1.0 (raw 2^W_FRAC) drives `spike_o` high for one cycle and clears the potential in the same cycle. A value one step below 1.0 does not fire.
- R7: After a spike the neuron is refractory until `cfg_refr_ticks_i` ticks have arrived. During that time events are discarded, the potential reads 0 and no spike occurs. The first event after the last refractory tick is integrated again.
- R8: The potential saturates at its most negative and most positive values instead of wrapping.
- R9: With `cfg_refr_ticks_i` = 0 there is no refractory window: an event in the cycle right after a spike is integrated and may fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | Input event present this cycle |
| ev_weight_i | input | W_INT+W_FRAC | Signed fixed-point synaptic weight of the event |
| tick_i | input | 1 | Time-step tick: apply leak, advance refractory count |
| cfg_leak_shift_i | input | $clog2(PW) | Leak shift amount k |
| cfg_refr_ticks_i | input | REFR_W | Refractory length in ticks |
| spike_o | output | 1 | Registered one-cycle output spike |
| v_mem_o | output | PW | Registered membrane potential, signed fixed point |

## Verification
The hardest state to reach from the ports is negative saturation. The threshold clears the potential long before the positive end of the range can be reached, so only a long run of strongly negative events can push the register to its floor. The stimulus therefore drives seventeen maximum-magnitude negative weights in a row and then leaks from the clamped value. A second corner is the boundary of the refractory window. Events are placed on the cycle of the final refractory tick and on the cycle just after it, to show that the first is dropped and the second is integrated.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int DEF_W_INT  = 3;
  localparam int DEF_W_FRAC = 4;
  localparam int DEF_GUARD  = 4;
  localparam int DEF_REFR_W = 8;

  function automatic int unsigned pot_width(input int unsigned wi, input int unsigned wf,
                                            input int unsigned g);
    return wi + wf + g;
  endfunction
endpackage

// File: rtl/lif_leak.sv
module lif_leak #(
  parameter int PW  = 11,
  parameter int SHW = 4
) (
  input  logic                 tick_i,
  input  logic        [SHW-1:0] shift_i,
  input  logic signed [PW-1:0] v_i,
  output logic signed [PW-1:0] v_o
);
  logic signed [PW-1:0] decay;

  always_comb begin
    decay = v_i >>> shift_i;
    v_o   = tick_i ? (v_i - decay) : v_i;
  end

  // R4: leak never moves a potential away from zero or across it
  always_comb begin
    if (tick_i && v_i >= 0) a_r4_leak_pos: assert (v_o >= 0 && v_o <= v_i);
    if (tick_i && v_i < 0)  a_r4_leak_neg: assert (v_o <= 0 && v_o >= v_i);
  end
endmodule

// File: rtl/lif_accum.sv
module lif_accum #(
  parameter int PW = 11,
  parameter int WW = 7
) (
  input  logic signed [PW-1:0] a_i,
  input  logic                 en_i,
  input  logic        [WW-1:0] w_i,
  output logic signed [PW-1:0] sum_o
);
  localparam logic signed [PW-1:0] VMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic signed [PW-1:0] VMIN = {1'b1, {(PW-1){1'b0}}};

  logic [PW:0] wide;
  logic [PW:0] wext;

  always_comb begin
    wext = en_i ? {{(PW+1-WW){w_i[WW-1]}}, w_i} : '0;
    wide = {a_i[PW-1], a_i} + wext;
    if (wide[PW] != wide[PW-1]) sum_o = wide[PW] ? VMIN : VMAX;
    else                        sum_o = wide[PW-1:0];
  end

  // R8: adding a negative weight never yields a larger value (no wrap), and vice versa
  always_comb begin
    if (en_i && w_i[WW-1])  a_r8_no_wrap_neg: assert (sum_o <= a_i);
    if (en_i && !w_i[WW-1]) a_r8_no_wrap_pos: assert (sum_o >= a_i);
  end
endmodule

// File: rtl/lif_refractory.sv
module lif_refractory #(
  parameter int REFR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [REFR_W-1:0] len_i,
  output logic              busy_o
);
  logic [REFR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (start_i)             cnt <= len_i;
    else if (tick_i && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  // R7: the count only drops on a tick
  a_r7_count_on_tick: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick_i && !start_i) |=> busy_o);
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int W_INT  = DEF_W_INT,
  parameter int W_FRAC = DEF_W_FRAC,
  parameter int GUARD  = DEF_GUARD,
  parameter int REFR_W = DEF_REFR_W,
  localparam int WW    = W_INT + W_FRAC,
  localparam int PW    = pot_width(W_INT, W_FRAC, GUARD),
  localparam int SHW   = $clog2(PW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid_i,
  input  logic [WW-1:0]     ev_weight_i,
  input  logic              tick_i,
  input  logic [SHW-1:0]    cfg_leak_shift_i,
  input  logic [REFR_W-1:0] cfg_refr_ticks_i,
  output logic              spike_o,
  output logic [PW-1:0]     v_mem_o
);
  localparam logic signed [PW-1:0] THR = PW'(1 << W_FRAC);

  logic signed [PW-1:0] v_q;
  logic signed [PW-1:0] v_leaked;
  logic signed [PW-1:0] v_post;
  logic                 busy;
  logic                 fire;
  logic                 spike_q;

  lif_leak #(.PW(PW), .SHW(SHW)) u_leak (
    .tick_i (tick_i),
    .shift_i(cfg_leak_shift_i),
    .v_i    (v_q),
    .v_o    (v_leaked)
  );

  lif_accum #(.PW(PW), .WW(WW)) u_accum (
    .a_i  (v_leaked),
    .en_i (ev_valid_i && !busy),
    .w_i  (ev_weight_i),
    .sum_o(v_post)
  );

  assign fire = !busy && (v_post >= THR);

  lif_refractory #(.REFR_W(REFR_W)) u_refr (
    .clk    (clk),
    .rst    (rst),
    .start_i(fire),
    .tick_i (tick_i),
    .len_i  (cfg_refr_ticks_i),
    .busy_o (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= '0;
      spike_q <= 1'b0;
    end else begin
      spike_q <= fire;
      if (busy || fire) v_q <= '0;
      else              v_q <= v_post;
    end
  end

  assign spike_o = spike_q;
  assign v_mem_o = v_q;

  // R6: a spike is always accompanied by a cleared potential
  a_r6_spike_clears: assert property (@(posedge clk) disable iff (rst)
    spike_o |-> (v_mem_o == '0));
  // R7: while refractory nothing integrates and nothing fires
  a_r7_quiet_refr: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!spike_o && v_mem_o == '0));
  // R6: below threshold the stored potential never sits at or above 1.0
  a_r6_below_thr: assert property (@(posedge clk) disable iff (rst)
    !spike_o |-> ($signed(v_mem_o) < THR));
endmodule

// File: tb/lif_neuron_tb.sv
module lif_neuron_tb;
  localparam int WW = 7;
  localparam int PW = 11;
  localparam int VMIN = -1024;
  localparam int VMAX = 1023;
  localparam int THR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [WW-1:0] ev_weight = '0;
  logic tick = 1'b0;
  logic [3:0] leak_k = 4'd2;
  logic [7:0] refr_len = 8'd3;
  logic spike;
  logic [PW-1:0] vmem;

  always #10 clk = ~clk;

  lif_neuron u_dut (
    .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_weight_i(ev_weight),
    .tick_i(tick), .cfg_leak_shift_i(leak_k), .cfg_refr_ticks_i(refr_len),
    .spike_o(spike), .v_mem_o(vmem)
  );

  typedef struct { int v; bit sp; string tag; } exp_t;
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_v = 0;
  int m_busy = 0;

  function automatic int sat(input int x);
    if (x > VMAX) return VMAX;
    if (x < VMIN) return VMIN;
    return x;
  endfunction

  task automatic step(input bit ev, input int w, input bit tk, input string tag);
    exp_t e;
    int vt;
    @(negedge clk);
    ev_valid  = ev;
    ev_weight = WW'(w);
    tick      = tk;
    e.sp = 1'b0;
    if (m_busy > 0) begin
      if (tk) m_busy--;
      m_v = 0;
    end else begin
      vt = tk ? (m_v - (m_v >>> leak_k)) : m_v;
      if (ev) vt = sat(vt + w);
      if (vt >= THR) begin
        e.sp = 1'b1; m_v = 0; m_busy = refr_len;
      end else m_v = vt;
    end
    e.v = m_v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ev_valid = 1'b0; tick = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_v = 0; m_busy = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ($signed(vmem) != e.v || spike != e.sp) begin
        errors++;
        $display("FAIL %s: v=%0d spike=%0b expected v=%0d spike=%0b",
                 e.tag, $signed(vmem), spike, e.v, e.sp);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 0, 1'b0, "R1 reset state");
    step(1'b1, 4, 1'b0, "R2 add +0.25");
    step(1'b1, 4, 1'b0, "R2 add +0.25 again");
    step(1'b1, 0, 1'b0, "R3 zero weight");
    step(1'b0, 0, 1'b1, "R4 leak positive");
    step(1'b1, 4, 1'b1, "R5 leak then add");
    step(1'b1, 6, 1'b0, "R6 one step below threshold");
    step(1'b1, 1, 1'b0, "R6 reach threshold");
    step(1'b1, 20, 1'b0, "R7 event discarded");
    step(1'b0, 0, 1'b1, "R7 tick 1");
    step(1'b1, 10, 1'b1, "R7 tick 2 with event");
    step(1'b1, 30, 1'b1, "R7 last tick with event");
    step(1'b1, 5, 1'b0, "R7 resumes integration");
    for (int i = 0; i < 17; i++) step(1'b1, -64, 1'b0, "R8 negative saturation");
    step(1'b0, 0, 1'b1, "R4 leak negative from floor");
    step(1'b1, -64, 1'b1, "R8 leak and negative add");
    do_reset();
    step(1'b0, 0, 1'b0, "R1 state after mid-run reset");
    refr_len = 8'd0;
    step(1'b1, 16, 1'b0, "R9 fire with no refractory");
    step(1'b1, 20, 1'b0, "R9 immediate refire");
    step(1'b1, 3, 1'b0, "R9 integrates after spike");
    step(1'b0, 0, 1'b0, "R9 idle hold");
    @(negedge clk);
    ev_valid = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule